// File: doc/BRIEF.md
# Byte-Wide Indirect Register Access Port

This block sits on the target side of a narrow 8-bit host bus with only four register slots. It gives a small host access to a 16-bit internal address space. The host loads a 16-bit pointer one byte at a time, using two address slots. It then reads or writes a single data slot, and each data access is forwarded to the internal memory port at the pointer.

A mode slot controls three things:
- It turns indirect operation on.
- It turns on automatic pointer stepping, so a burst of bytes can stream through the one data slot after a single pointer load.
- It can issue a software reset that clears itself.

Every host read completes one cycle after its request. The block raises a valid flag with the returned byte. For a data read, that byte comes straight from the internal memory, whose read latency is one cycle.

Top module: `ind_reg_port`

## Requirements
- R1: After the reset input is released, the mode slot (offset 0) reads 0x00 and both pointer slots (offset 1 = high byte, offset 2 = low byte) read 0x00.
- R2: A host write to offset 1 loads the pointer's high byte and a write to offset 2 loads its low byte. Reads of these offsets return the current pointer, including any steps taken.
- R3: With indirect mode on, a host write to offset 3 drives a memory write request in the same cycle, at the current pointer, carrying the host byte.
- R4: With indirect mode on, a host read of offset 3 drives a memory read request at the current pointer. The byte returned one cycle later is the memory content at the address before any step.
- R5: Mode bit 1 enables stepping. When it is set, each data access (read or write) advances the pointer by one. When it is clear, the pointer is left unchanged.
- R6: When stepping is enabled, the pointer steps from 0xFFFF to 0x0000.
- R7: Mode bit 0 enables indirect operation. While it is clear, data accesses make no memory request, do not move the pointer and read back 0x00.
- R8: Writing mode bit 7 as 1 returns the mode and the pointer to 0x00 on that clock edge, whatever the other bits written. Bit 7 always reads back as 0.
- R9: Every host read raises `host_rvalid` for exactly the cycle after the request. Register reads return the value held when the request was made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_off | input | 2 | Register slot offset |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid with host_rvalid |
| host_rvalid | output | 1 | Read response valid |
| mem_req | output | 1 | Internal memory access request |
| mem_we | output | 1 | Internal memory write enable |
| mem_addr | output | 16 | Internal memory address (current pointer) |
| mem_wdata | output | 8 | Internal memory write byte |
| mem_rdata | input | 8 | Internal memory read byte, one cycle after a read request |

## Verification
Memory requests are combinational from the host strobe. The bench samples `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` a short delay after it drives the strobe, within the same cycle.

Read data and `host_rvalid` are due one clock edge after the request. The bench samples them at the next falling edge, after the strobe has been dropped.

Pointer steps and mode changes take effect at the edge that ends the access. Their effect is seen through a register read issued in a later cycle. The sweep covers all four mode settings across several base addresses, including the 0xFFFF wrap.

// File: rtl/ind_port_pkg.sv
package ind_port_pkg;
  typedef enum logic [1:0] {
    OFF_MODE = 2'd0,
    OFF_AHI  = 2'd1,
    OFF_ALO  = 2'd2,
    OFF_DATA = 2'd3
  } host_off_e;

  localparam int MODE_IND_BIT = 0;
  localparam int MODE_STEP_BIT = 1;
  localparam int MODE_RST_BIT = 7;
endpackage

// File: rtl/ind_mode_reg.sv
module ind_mode_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic              soft_rst,
  output logic              ind_en,
  output logic              step_en
);
  import ind_port_pkg::*;

  logic ind_d, step_d;

  assign soft_rst = wr_en & wdata[MODE_RST_BIT];

  always_comb begin
    ind_d  = ind_en;
    step_d = step_en;
    if (soft_rst) begin
      ind_d  = 1'b0;
      step_d = 1'b0;
    end else if (wr_en) begin
      ind_d  = wdata[MODE_IND_BIT];
      step_d = wdata[MODE_STEP_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ind_en  <= 1'b0;
      step_en <= 1'b0;
    end else begin
      ind_en  <= ind_d;
      step_en <= step_d;
    end
  end
endmodule

// File: rtl/ind_addr_ptr.sv
module ind_addr_ptr #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic              step,
  input  logic [DATA_W-1:0] wdata,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] addr_d;
  logic              addr_en;

  assign addr_en = soft_rst | wr_hi | wr_lo | step;

  always_comb begin
    addr_d = addr;
    if (soft_rst)   addr_d = '0;
    else if (wr_hi) addr_d = {wdata, addr[DATA_W-1:0]};
    else if (wr_lo) addr_d = {addr[ADDR_W-1:DATA_W], wdata};
    else if (step)  addr_d = addr + {{(ADDR_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr <= '0;
    else if (addr_en) addr <= addr_d;
  end
endmodule

// File: rtl/ind_rsp.sv
module ind_rsp #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              rd_mem,
  input  logic [DATA_W-1:0] reg_val,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata
);
  logic              sel_mem_q;
  logic [DATA_W-1:0] reg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid    <= 1'b0;
      sel_mem_q <= 1'b0;
    end else begin
      rvalid    <= rd_req;
      sel_mem_q <= rd_req & rd_mem;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_q <= '0;
    else if (rd_req) reg_q <= reg_val;
  end

  assign rdata = sel_mem_q ? mem_rdata : reg_q;
endmodule

// File: rtl/ind_reg_port.sv
module ind_reg_port #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [1:0]        host_off,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  import ind_port_pkg::*;

  logic              wr_mode, wr_hi, wr_lo, data_hit, rd_req;
  logic              soft_rst, ind_en, step_en;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] reg_val;

  assign wr_mode  = host_req & host_we & (host_off == OFF_MODE);
  assign wr_hi    = host_req & host_we & (host_off == OFF_AHI);
  assign wr_lo    = host_req & host_we & (host_off == OFF_ALO);
  assign data_hit = host_req & (host_off == OFF_DATA) & ind_en;
  assign rd_req   = host_req & ~host_we;

  ind_mode_reg #(.DATA_W(DATA_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_mode), .wdata(host_wdata),
    .soft_rst(soft_rst), .ind_en(ind_en), .step_en(step_en));

  ind_addr_ptr #(.DATA_W(DATA_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_hi(wr_hi),
    .wr_lo(wr_lo), .step(data_hit & step_en), .wdata(host_wdata),
    .addr(addr));

  always_comb begin
    reg_val = '0;
    case (host_off)
      OFF_MODE: begin
        reg_val[MODE_IND_BIT]  = ind_en;
        reg_val[MODE_STEP_BIT] = step_en;
      end
      OFF_AHI: reg_val = addr[ADDR_W-1:DATA_W];
      OFF_ALO: reg_val = addr[DATA_W-1:0];
      default: reg_val = '0;
    endcase
  end

  ind_rsp #(.DATA_W(DATA_W)) u_rsp (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_mem(data_hit),
    .reg_val(reg_val), .mem_rdata(mem_rdata),
    .rvalid(host_rvalid), .rdata(host_rdata));

  assign mem_req   = data_hit;
  assign mem_we    = data_hit & host_we;
  assign mem_addr  = addr;
  assign mem_wdata = host_wdata;
endmodule

// File: rtl/ind_reg_port_chk.sv
module ind_reg_port_chk #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_req,
  input logic              host_we,
  input logic [1:0]        host_off,
  input logic [DATA_W-1:0] host_wdata,
  input logic              host_rvalid,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              ind_en,
  input logic              step_en
);
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && step_en) |=> (mem_addr == $past(mem_addr) + 1'b1)); // R5

  AST_HOLD_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !step_en) |=> (mem_addr == $past(mem_addr))); // R5

  AST_NO_REQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !ind_en |-> !mem_req); // R7

  AST_RD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_we) |=> host_rvalid); // R9

  AST_RD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_req && !host_we) |=> !host_rvalid); // R9

  AST_SOFT_RST: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_we && host_off == 2'd0 && host_wdata[7])
    |=> (!ind_en && !step_en && mem_addr == '0)); // R8
endmodule

bind ind_reg_port ind_reg_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
  .host_off(host_off), .host_wdata(host_wdata), .host_rvalid(host_rvalid),
  .mem_req(mem_req), .mem_addr(mem_addr), .ind_en(ind_en),
  .step_en(step_en));

// File: tb/test_ind_reg_port.sv
module test_ind_reg_port;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        host_req, host_we;
  logic [1:0]  host_off;
  logic [7:0]  host_wdata, host_rdata, mem_wdata, mem_rdata;
  logic        host_rvalid, mem_req, mem_we;
  logic [15:0] mem_addr;

  int total = 0, bad = 0;
  bit done = 0;

  logic [7:0] mem_model [int];
  logic [7:0] exp_model [int];

  logic        s_req, s_we;
  logic [15:0] s_addr;
  logic [7:0]  s_wdata, rd_val;
  logic        rd_vld;

  ind_reg_port i_ind_reg_port (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_off(host_off), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] init_val(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  always @(posedge clk) begin
    if (mem_req && mem_we) mem_model[int'(mem_addr)] = mem_wdata;
    if (mem_req && !mem_we)
      mem_rdata <= mem_model.exists(int'(mem_addr)) ?
                   mem_model[int'(mem_addr)] : init_val(mem_addr);
  end

  function automatic logic [7:0] exp_byte(input logic [15:0] a);
    return exp_model.exists(int'(a)) ? exp_model[int'(a)] : init_val(a);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [1:0] off, input logic [7:0] d);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b1; host_off = off; host_wdata = d;
    #1;
    s_req = mem_req; s_we = mem_we; s_addr = mem_addr; s_wdata = mem_wdata;
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0;
  endtask

  task automatic hrd(input logic [1:0] off);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b0; host_off = off;
    #1;
    s_req = mem_req; s_we = mem_we; s_addr = mem_addr;
    @(negedge clk);
    host_req = 1'b0;
    rd_vld = host_rvalid; rd_val = host_rdata;
  endtask

  task automatic chk_ptr(input string req, input logic [15:0] exp);
    hrd(2'd1);
    check(req, {rd_vld, rd_val}, {1'b1, exp[15:8]});
    hrd(2'd2);
    check(req, {rd_vld, rd_val}, {1'b1, exp[7:0]});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] bases [3];
    bases[0] = 16'h1234; bases[1] = 16'hFFFE; bases[2] = 16'h00FF;
    host_req = 0; host_we = 0; host_off = 0; host_wdata = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    hrd(2'd0); check("R1 mode", {rd_vld, rd_val}, 9'h100);
    chk_ptr("R1 ptr", 16'h0000);
    // R9 no response without read
    @(negedge clk); check("R9 idle rvalid", host_rvalid, 0);

    for (int m = 0; m < 4; m++) begin
      for (int b = 0; b < 3; b++) begin
        logic        ind, stp;
        logic [15:0] p;
        ind = m[0]; stp = m[1];
        hwr(2'd0, 8'(m));
        hrd(2'd0); check("R9 mode readback", rd_val, m);
        hwr(2'd1, bases[b][15:8]);
        hwr(2'd2, bases[b][7:0]);
        chk_ptr("R2 ptr load", bases[b]);
        p = bases[b];
        for (int k = 0; k < 3; k++) begin
          logic [7:0] d;
          d = 8'(bases[b][7:0] + k * 7 + m * 16);
          hwr(2'd3, d);
          if (ind) begin
            check("R3 write req", {s_req, s_we}, 2'b11);
            check("R3 write addr", s_addr, p);
            check("R3 write data", s_wdata, d);
            exp_model[int'(p)] = d;
            if (stp) p = p + 16'd1;
          end else begin
            check("R7 no write req", s_req, 0);
          end
        end
        chk_ptr(stp && ind ? (bases[b] == 16'hFFFE ? "R6 wrap" : "R5 step")
                           : "R5 hold", p);
        hwr(2'd1, bases[b][15:8]);
        hwr(2'd2, bases[b][7:0]);
        p = bases[b];
        for (int k = 0; k < 3; k++) begin
          hrd(2'd3);
          if (ind) begin
            check("R4 read req", {s_req, s_we, s_addr}, {2'b10, p});
            check("R4 read data", {rd_vld, rd_val}, {1'b1, exp_byte(p)});
            if (stp) p = p + 16'd1;
          end else begin
            check("R7 read zero", {s_req, rd_vld, rd_val}, {2'b01, 8'h00});
          end
        end
        chk_ptr("R5 after reads", p);
      end
    end

    // R6 explicit wrap landing
    hwr(2'd0, 8'h03); hwr(2'd1, 8'hFF); hwr(2'd2, 8'hFF);
    hwr(2'd3, 8'h77);
    check("R6 write at FFFF", s_addr, 16'hFFFF);
    chk_ptr("R6 wrap to 0000", 16'h0000);

    // R8 software reset
    hwr(2'd1, 8'hAB); hwr(2'd2, 8'hCD);
    hwr(2'd0, 8'h83);
    hrd(2'd0); check("R8 mode cleared", {rd_vld, rd_val}, 9'h100);
    chk_ptr("R8 ptr cleared", 16'h0000);
    hrd(2'd3); check("R8 indirect off", {s_req, rd_val}, 9'h000);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule